// File: doc/BRIEF.md
# Write-Once Software Watchdog

This block is a software watchdog timer whose configuration sits in one 32-bit control word. After each system reset, software may write that word once; the block ignores every later write, and the word can be read at any time. The word holds a reload count, an enable, a prescale select and a select that routes expiry to a reset request or to an interrupt. Out of reset the watchdog is already running with the largest count and the prescaler on. A boot image that does not want the watchdog must clear the enable in its single write.

While it runs, a down-counter is reloaded from the count field. It steps once per clock, or once per 2048 clocks when the prescaler is selected. Software keeps it from expiring by writing a fixed two-value key pair to a separate service port. On expiry, the block either gives a one-cycle machine-check interrupt pulse or holds a soft-reset request for one cycle, and the counter reloads itself. The core's interrupt logic and the reset sequencer sit outside this block.

Top module: `swdog_guard`

## Requirements
- R1: After reset, `cfg_rdata` reads 0xFFFF_0007: count all ones, enable 1, route 1 and prescale 1. `irq_pulse` and `rst_req` are low.
- R2: The first `cfg_wr` after reset is stored. Every later `cfg_wr` leaves `cfg_rdata` and the timing unchanged. Reads are always valid.
- R3: The word layout is: count in bits [31:16], enable in bit 2, route in bit 1 and prescale in bit 0. Bits [15:3] are not stored and read as zero.
- R4: With enable=1 and prescale=0, the first expiry is seen N+1 cycles after the clock edge that accepts the write, where N is the count field (N>=2). Later expiries then repeat every N cycles.
- R5: With prescale=1, every counter step takes 2048 clocks. The first expiry is then seen 2048*N+1 cycles after the accepting edge.
- R6: With route=0, an expiry raises `irq_pulse` for exactly one cycle and never raises `rst_req`.
- R7: With route=1, an expiry raises `rst_req` for exactly one cycle and never raises `irq_pulse`.
- R8: A service write of 0x556C followed by a service write of 0xAA39 reloads the counter and clears the prescaler at the 0xAA39 edge. The next expiry is then seen N*step cycles after that edge.
- R9: The 0xAA39 write reloads nothing in two cases: when another value was written between the pair, or when 0xAA39 comes without a preceding 0x556C. The expiry schedule is then unchanged.
- R10: With enable=0, no expiry occurs and service writes have no visible effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read data |
| svc_wr | input | 1 | Service port write strobe |
| svc_wdata | input | 16 | Service port write data |
| irq_pulse | output | 1 | Machine-check interrupt pulse on expiry |
| rst_req | output | 1 | Soft-reset request on expiry |

## Verification
The properties assume that the route bit changes only through the one accepted control write. They also assume that a service write lasts a single cycle, so each strobe counts as one key entry. The stimulus raises every strobe for exactly one clock and writes the control word straight after reset. Random trials draw count values of 8 or more, so the key pair or a broken sequence always lands well before the next expiry. Random filler values are steered away from the two key values, so a sequence meant to be broken is never accidentally re-armed.

// File: rtl/swdog_pkg.sv
package swdog_pkg;

  localparam int CFG_W = 32;
  localparam int CNT_W = 16;

  typedef struct packed {
    logic [CNT_W-1:0] count;
    logic             enable;
    logic             route_rst;
    logic             prescale;
  } wd_cfg_t;

  localparam wd_cfg_t CFG_RESET = '{count: '1, enable: 1'b1, route_rst: 1'b1, prescale: 1'b1};

  // Bits [15:3] are not stored and always read back as zero.
  function automatic logic [CFG_W-1:0] cfg_pack(input wd_cfg_t c);
    return {c.count, 13'b0, c.enable, c.route_rst, c.prescale};
  endfunction

  function automatic wd_cfg_t cfg_unpack(input logic [CFG_W-1:0] w);
    wd_cfg_t c;
    c.count     = w[31:16];
    c.enable    = w[2];
    c.route_rst = w[1];
    c.prescale  = w[0];
    return c;
  endfunction

  // A count field of 0 behaves like 1.
  function automatic logic [CNT_W-1:0] eff_count(input logic [CNT_W-1:0] n);
    return (n == '0) ? CNT_W'(1) : n;
  endfunction

endpackage

// File: rtl/swdog_cfg_reg.sv
module swdog_cfg_reg
  import swdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  output wd_cfg_t          cfg,
  output logic [CFG_W-1:0] rdata,
  output logic             locked,
  output logic             fresh
);

  wd_cfg_t cfg_q;
  logic    locked_q;
  logic    fresh_q;
  logic    accept;

  assign accept = wr & ~locked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= CFG_RESET;
      locked_q <= 1'b0;
      fresh_q  <= 1'b0;
    end else begin
      fresh_q <= accept;
      if (accept) begin
        cfg_q    <= cfg_unpack(wdata);
        locked_q <= 1'b1;
      end
    end
  end

  assign cfg    = cfg_q;
  assign rdata  = cfg_pack(cfg_q);
  assign locked = locked_q;
  assign fresh  = fresh_q;

endmodule

// File: rtl/swdog_svc_seq.sv
module swdog_svc_seq #(
  parameter int          KW    = 16,
  parameter logic [KW-1:0] KEY_A = 16'h556C,
  parameter logic [KW-1:0] KEY_B = 16'hAA39
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [KW-1:0] wdata,
  output logic          done,
  output logic          armed
);

  logic armed_q;

  assign done = wr & armed_q & (wdata == KEY_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (wr) begin
      armed_q <= (wdata == KEY_A);
    end
  end

  assign armed = armed_q;

endmodule

// File: rtl/swdog_prescaler.sv
module swdog_prescaler #(
  parameter int DIV = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic bypass,
  input  logic clear,
  output logic tick
);

  generate
    if (DIV <= 1) begin : g_none
      assign tick = run;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pre_q;

      assign tick = run & (bypass | (pre_q == LAST));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pre_q <= '0;
        end else if (!run || bypass || clear || (pre_q == LAST)) begin
          pre_q <= '0;
        end else begin
          pre_q <= pre_q + PW'(1);
        end
      end
    end
  endgenerate

endmodule

// File: rtl/swdog_counter.sv
module swdog_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         reload,
  input  logic         tick,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         expire
);

  logic [W-1:0] cnt_q;

  assign expire = run & tick & ~reload & (cnt_q <= W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
    end else if (!run || reload || expire) begin
      cnt_q <= load_val;
    end else if (tick) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/swdog_guard.sv
module swdog_guard
  import swdog_pkg::*;
#(
  parameter int          PRE_DIV = 2048,
  parameter logic [15:0] KEY_A   = 16'h556C,
  parameter logic [15:0] KEY_B   = 16'hAA39
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             svc_wr,
  input  logic [15:0]      svc_wdata,
  output logic             irq_pulse,
  output logic             rst_req
);

  wd_cfg_t          cfg;
  logic             locked;
  logic             cfg_fresh;
  logic             svc_done;
  logic             svc_armed;
  logic             run;
  logic             route;
  logic             reload;
  logic             tick;
  logic             expire;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] count_field;
  logic             irq_q;
  logic             rst_q;

  swdog_cfg_reg i_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (cfg_wr),
    .wdata  (cfg_wdata),
    .cfg    (cfg),
    .rdata  (cfg_rdata),
    .locked (locked),
    .fresh  (cfg_fresh)
  );

  swdog_svc_seq #(.KW(16), .KEY_A(KEY_A), .KEY_B(KEY_B)) i_svc (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (svc_wr),
    .wdata (svc_wdata),
    .done  (svc_done),
    .armed (svc_armed)
  );

  assign run         = cfg.enable;
  assign route       = cfg.route_rst;
  assign count_field = cfg.count;
  assign reload      = svc_done | cfg_fresh;

  swdog_prescaler #(.DIV(PRE_DIV)) i_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .bypass (~cfg.prescale),
    .clear  (reload),
    .tick   (tick)
  );

  swdog_counter #(.W(CNT_W)) i_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .reload   (reload),
    .tick     (tick),
    .load_val (eff_count(count_field)),
    .cnt      (cnt),
    .expire   (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      irq_q <= expire & ~route;
      rst_q <= expire & route;
    end
  end

  assign irq_pulse = irq_q;
  assign rst_req   = rst_q;

endmodule

// File: rtl/swdog_guard_chk.sv
module swdog_guard_chk
  import swdog_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [CFG_W-1:0] cfg_rdata,
  input logic             irq_pulse,
  input logic             rst_req,
  input logic             locked,
  input logic             run,
  input logic             route,
  input logic             svc_done,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] count_field
);

  p_lock_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(cfg_rdata));

  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[15:3] == 13'b0);

  p_irq_route_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> !$past(route));

  p_rst_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(route));

  p_outputs_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_pulse && rst_req));

  p_service_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    svc_done |=> (cnt == eff_count($past(count_field))));

  p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!irq_pulse && !rst_req));

endmodule

bind swdog_guard swdog_guard_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_rdata   (cfg_rdata),
  .irq_pulse   (irq_pulse),
  .rst_req     (rst_req),
  .locked      (locked),
  .run         (run),
  .route       (route),
  .svc_done    (svc_done),
  .cnt         (cnt),
  .count_field (count_field)
);

// File: tb/test_swdog_guard.sv
module test_swdog_guard;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        svc_wr = 1'b0;
  logic [15:0] svc_wdata = '0;
  logic        irq_pulse;
  logic        rst_req;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done_flag = 0;

  localparam int STEP_PRE = 2048;
  localparam logic [15:0] KA = 16'h556C;
  localparam logic [15:0] KB = 16'hAA39;

  swdog_guard i_swdog_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .svc_wr    (svc_wr),
    .svc_wdata (svc_wdata),
    .irq_pulse (irq_pulse),
    .rst_req   (rst_req)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Bench model: visible readback and interval arithmetic, written from the requirements.
  function automatic logic [31:0] model_read(input logic [31:0] w);
    return {w[31:16], 16'h0} | {29'h0, w[2:0]};
  endfunction

  function automatic int model_interval(input int n, input bit pre);
    int m;
    m = (n < 1) ? 1 : n;
    return pre ? m * STEP_PRE : m;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_wr = 1'b0; svc_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [31:0] d, output int edge_at);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    edge_at = cyc;
  endtask

  task automatic svc_write(input logic [15:0] d, output int edge_at);
    @(negedge clk);
    svc_wr = 1'b1; svc_wdata = d;
    @(negedge clk);
    svc_wr = 1'b0;
    edge_at = cyc;
  endtask

  task automatic wait_evt(input int limit, output int at, output bit w_irq, output bit w_rst);
    at = -1; w_irq = 0; w_rst = 0;
    for (int k = 0; k < limit; k++) begin
      @(negedge clk);
      if (irq_pulse || rst_req) begin
        at = cyc; w_irq = irq_pulse; w_rst = rst_req;
        break;
      end
    end
  endtask

  // One expiry, then a check that the output drops after a single cycle.
  task automatic expect_evt(input int exp_at, input bit route, input string req);
    int at; bit wi; bit wr_;
    wait_evt(exp_at - cyc + 5, at, wi, wr_);
    chk(at == exp_at, req, "expiry cycle", at, exp_at);
    chk(wi == !route && wr_ == route, route ? "R7" : "R6", "output select",
        {wi, wr_}, {!route, route});
    @(negedge clk);
    chk(!irq_pulse && !rst_req, route ? "R7" : "R6", "one-cycle width",
        {irq_pulse, rst_req}, 0);
  endtask

  initial begin : watchdog
    wait (cyc > 150000);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int e0, e1, a, b, c, n, last, cnt_ev, at;
    bit route, wi, wr_, brk;
    logic [31:0] w;
    logic [15:0] junk;
    void'($urandom(32'd4711));

    // R1 reset state
    do_reset();
    chk(cfg_rdata == 32'hFFFF_0007, "R1", "reset readback", cfg_rdata, 32'hFFFF_0007);
    chk(!irq_pulse && !rst_req, "R1", "outputs after reset", {irq_pulse, rst_req}, 0);

    // R2/R3/R4/R6 directed: N=37, unprescaled, interrupt route, reserved bits set
    w = 32'h0025_FFFC;
    cfg_write(w, e0);
    chk(cfg_rdata == model_read(w), "R3", "layout readback", cfg_rdata, model_read(w));
    cfg_write(32'h0005_0007, e1);
    chk(cfg_rdata == model_read(w), "R2", "second write ignored", cfg_rdata, model_read(w));
    last = e0 + 1 + model_interval(37, 0);
    expect_evt(last, 0, "R4");
    last = last + 37;
    expect_evt(last, 0, "R4");

    // R8 good pair
    svc_write(KA, a);
    svc_write(KB, b);
    last = b + 37;
    expect_evt(last, 0, "R8");

    // R9 broken pair: filler between the keys
    svc_write(KA, a);
    svc_write(16'h1234, a);
    svc_write(KB, b);
    last = last + 37;
    expect_evt(last, 0, "R9");

    // R9 second key alone
    svc_write(KB, b);
    last = last + 37;
    expect_evt(last, 0, "R9");

    // R5/R7 prescaled, N=3, reset route
    do_reset();
    w = 32'h0003_0007;
    cfg_write(w, e0);
    expect_evt(e0 + 1 + model_interval(3, 1), 1, "R5");

    // R10 disabled
    do_reset();
    cfg_write(32'h0005_0000, e0);
    cnt_ev = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (irq_pulse || rst_req) cnt_ev++;
    end
    svc_write(KA, a);
    svc_write(KB, b);
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (irq_pulse || rst_req) cnt_ev++;
    end
    chk(cnt_ev == 0, "R10", "no expiry while disabled", cnt_ev, 0);

    // Random trials: count, route, reserved noise and service pattern
    for (int t = 0; t < 8; t++) begin
      n = 8 + int'($urandom % 50);
      route = 1'($urandom % 2);
      brk = 1'($urandom % 2);
      do_reset();
      w = {16'(n), 16'($urandom) & 16'hFFF8} | {29'h0, 1'b1, route, 1'b0};
      cfg_write(w, e0);
      chk(cfg_rdata == model_read(w), "R3", "random readback", cfg_rdata, model_read(w));
      last = e0 + 1 + model_interval(n, 0);
      expect_evt(last, route, "R4");
      svc_write(KA, a);
      if (brk) begin
        junk = 16'($urandom);
        if (junk == KA || junk == KB) junk = junk ^ 16'h0001;
        svc_write(junk, c);
      end
      svc_write(KB, b);
      last = brk ? last + n : b + n;
      expect_evt(last, route, brk ? "R9" : "R8");
    end

    // R2: late write after running still ignored
    cfg_write(32'h0000_0000, e1);
    chk(cfg_rdata == model_read(w), "R2", "late write ignored", cfg_rdata, model_read(w));
    wait_evt(100, at, wi, wr_);
    chk(at == last + n, "R2", "timing unchanged", at, last + n);

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule